// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Collision and Mode-Fault Detection

This block moves one 8-bit byte in each direction at the same time over a four-wire synchronous serial link. It can act as the bus master, driving the serial clock at one of four rates derived from the system clock, or as a slave that follows a clock arriving on a pin. Software chooses the idle level of the serial clock and on which clock edge data is sampled. All control, status and data access goes through a small register port, and one interrupt line reports the end of a transfer and any error.

Two error detectors protect the link. A write to the data register while a byte is still shifting is dropped and flagged as a collision, and the byte in flight continues untouched. If the slave-select input is pulled low while the block is master, another device is contending for the bus. The block then flags a mode fault, leaves master mode and releases its clock and data output drivers.

Top module: `spi_duplex_unit`

## Requirements
- R1: After reset the control, status and data registers read 0x00, all three output enables are low and `irq_o` is low.
- R2: In master mode the control rate field (bits 5:4) gives a serial-clock half period of 2, 4, 8 or 16 system clocks for codes 0, 1, 2 and 3, which is a divide by 4, 8, 16 or 32. One byte takes exactly 16 serial-clock edges.
- R3: A master transfer starts on a write to the data register (address 2). It shifts the written byte out on `mosi_o`, most significant bit first. At the same time it shifts a byte in from `miso_i`, and reading address 2 afterwards returns that byte.
- R4: `sck_o` rests at the polarity bit (control bit 2). With the phase bit (control bit 3) at 0, data is sampled on the leading edge and the first bit is valid before that edge. With the phase bit at 1, data changes on the leading edge and is sampled on the trailing edge.
- R5: The completion flag (status bit 7) sets after the eighth bit has been sampled.
- R6: The completion and collision flags are cleared by a status read (address 1) that sees either flag set, followed by an access to the data register. An access to the data register with no such status read first leaves them set.
- R7: A data write while a transfer is in progress sets the collision flag (status bit 6). The written byte is discarded and the byte in flight completes unchanged.
- R8: With the block enabled as master (control bits 0 and 1), a low level on the synchronised `ss_ni` sets the mode-fault flag (status bit 4). It also clears the master bit and drives `sck_oe_o` and `mosi_oe_o` low.
- R9: In slave mode (control bit 0 set, bit 1 clear) `sck_i`, `mosi_i` and `ss_ni` pass through a two-flop synchroniser. The slave shifts on the edges of the synchronised clock while selected, drives `miso_o` with `miso_oe_o` high only while `ss_ni` is low, and receives the byte seen on `mosi_i`.
- R10: `irq_o` is high when the interrupt-enable bit (control bit 6) is set and any of the completion, collision or mode-fault flags is set.
- R11: The mode-fault flag is cleared only by a status read that sees it set, followed by a write to the control register (address 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on flags) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line from the pin (slave receive) |
| mosi_o | output | 1 | Master-out line to the pin (master transmit) |
| mosi_oe_o | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line from the pin (master receive) |
| miso_o | output | 1 | Master-in line to the pin (slave transmit) |
| miso_oe_o | output | 1 | Master-in output enable |
| ss_ni | input | 1 | Slave select, active low |

## Verification
The bench runs all four polarity and phase combinations at all four rates against a behavioural partner. It checks the half period and the edge count, so a divider that is off by one or a transfer that stops one edge early shows up as a wrong interval or a corrupted byte. It writes the data register in the middle of a transfer: a design that loads the new byte sends a mixed pattern instead of the original, and one that ignores the write never raises the collision flag. It tests the flag-clearing sequences both ways round, so a flag that clears on any data access, or a mode fault that clears on a plain control write, is caught. The mode-fault case checks that the output enables fall and that the master bit reads back as cleared.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RATE_W      = 2;
  localparam int unsigned DIV_CNT_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int unsigned STAT_DONE = 7;
  localparam int unsigned STAT_WCOL = 6;
  localparam int unsigned STAT_MODF = 4;

  typedef struct packed {
    logic              irq_en;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] sel_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  // half period = 2 << sel system clocks
  assign half_m1 = CNT_W'((32'd2 << sel_i) - 32'd1);
  assign tick_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              go_i,
  input  logic              edge_i,
  input  logic              abort_i,
  input  logic              cpha_i,
  input  logic              rx_i,
  output logic              busy_o,
  output logic              phase_o,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] shreg_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(2*DATA_W);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(2*DATA_W-1);

  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              tx_q;
  logic              done_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (load_i) begin
        sh_q  <= data_i;
        tx_q  <= data_i[DATA_W-1];
        run_q <= go_i;
        cnt_q <= '0;
      end else if (edge_i) begin
        // even count = leading edge; sample edge selected by phase
        if (cnt_q[0] == cpha_i) sh_q <= {sh_q[DATA_W-2:0], rx_i};
        else                    tx_q <= sh_q[DATA_W-1];
        if (cnt_q == LAST_EDGE) begin
          cnt_q  <= '0;
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o   = run_q || (cnt_q != '0);
  assign phase_o  = cnt_q[0];
  assign tx_bit_o = tx_q;
  assign shreg_o  = sh_q;
  assign done_o   = done_q;
endmodule

// File: rtl/spi_duplex_unit.sv
module spi_duplex_unit
  import spi_duplex_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_ni
);
  ctrl_t             ctrl_q;
  logic              done_q, wcol_q, modf_q;
  logic              arm_xfer_q, arm_modf_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic              sck_prev_q;

  logic              ss_s, mosi_s, sck_s;
  logic              is_master, is_slave, mode_fault;
  logic              wr_ctrl, rd_stat, acc_data, wr_data;
  logic              collide, load, abort;
  logic              eng_busy, eng_phase, eng_tx, eng_done;
  logic [DATA_W-1:0] eng_sh;
  logic              tick, slv_edge, edge_sel, rx_sel, drive_master;

  spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   ({ss_s, mosi_s, sck_s})
  );

  assign is_master  = ctrl_q.en && ctrl_q.master;
  assign is_slave   = ctrl_q.en && !ctrl_q.master;
  assign mode_fault = is_master && !ss_s;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign rd_stat  = rd_en_i && (addr_i == ADDR_STAT);
  assign wr_data  = wr_en_i && (addr_i == ADDR_DATA);
  assign acc_data = (wr_en_i || rd_en_i) && (addr_i == ADDR_DATA);

  assign collide = wr_data && eng_busy;
  assign load    = wr_data && !eng_busy && !mode_fault;
  assign abort   = eng_busy && (mode_fault || !ctrl_q.en || (is_slave && ss_s));

  spi_rate_gen #(
    .RATE_W(RATE_W),
    .CNT_W (DIV_CNT_W)
  ) i_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (is_master && eng_busy),
    .sel_i (ctrl_q.rate),
    .tick_o(tick)
  );

  assign slv_edge = is_slave && !ss_s && (sck_s != sck_prev_q);
  assign edge_sel = is_master ? tick : slv_edge;
  assign rx_sel   = is_master ? miso_i : mosi_s;

  spi_shift_engine #(
    .DATA_W(DATA_W)
  ) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (wdata_i),
    .go_i    (is_master),
    .edge_i  (edge_sel),
    .abort_i (abort),
    .cpha_i  (ctrl_q.cpha),
    .rx_i    (rx_sel),
    .busy_o  (eng_busy),
    .phase_o (eng_phase),
    .tx_bit_o(eng_tx),
    .shreg_o (eng_sh),
    .done_o  (eng_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      if (wr_ctrl)    ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (mode_fault) ctrl_q.master <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      wcol_q     <= 1'b0;
      modf_q     <= 1'b0;
      arm_xfer_q <= 1'b0;
      arm_modf_q <= 1'b0;
      rx_buf_q   <= '0;
    end else begin
      if (eng_done) rx_buf_q <= eng_sh;

      if (eng_done)                      done_q <= 1'b1;
      else if (acc_data && arm_xfer_q)   done_q <= 1'b0;

      if (collide)                       wcol_q <= 1'b1;
      else if (acc_data && arm_xfer_q)   wcol_q <= 1'b0;

      if (rd_stat)       arm_xfer_q <= done_q || wcol_q;
      else if (acc_data) arm_xfer_q <= 1'b0;

      if (mode_fault)                    modf_q <= 1'b1;
      else if (wr_ctrl && arm_modf_q)    modf_q <= 1'b0;

      if (rd_stat)      arm_modf_q <= modf_q;
      else if (wr_ctrl) arm_modf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: begin
        rdata_o[STAT_DONE] = done_q;
        rdata_o[STAT_WCOL] = wcol_q;
        rdata_o[STAT_MODF] = modf_q;
      end
      ADDR_DATA: rdata_o = rx_buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.irq_en && (done_q || wcol_q || modf_q);

  assign drive_master = is_master && !modf_q;
  assign sck_o        = ctrl_q.cpol ^ eng_phase;
  assign sck_oe_o     = drive_master;
  assign mosi_o       = eng_tx;
  assign mosi_oe_o    = drive_master;
  assign miso_o       = eng_tx;
  assign miso_oe_o    = is_slave && !ss_s;
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic sck_oe_i,
  input logic mosi_oe_i,
  input logic cpol_i,
  input logic master_i,
  input logic busy_i,
  input logic modf_i,
  input logic done_i,
  input logic wcol_i
);
  // R8
  modf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_i |-> (!sck_oe_i && !mosi_oe_i));

  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_i && !busy_i) |-> (sck_i == cpol_i));

  // R2
  sck_min_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && busy_i && ($past(sck_i) != sck_i)) |=> $stable(sck_i));

  // R7
  wcol_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_i) |-> $past(busy_i));

  // R5
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i, 2));
endmodule

bind spi_duplex_unit spi_duplex_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_o),
  .sck_oe_i (sck_oe_o),
  .mosi_oe_i(mosi_oe_o),
  .cpol_i   (ctrl_q.cpol),
  .master_i (is_master),
  .busy_i   (eng_busy),
  .modf_i   (modf_q),
  .done_i   (done_q),
  .wcol_i   (wcol_q)
);

// File: tb/test_spi_duplex_unit.sv
module test_spi_duplex_unit;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       irq;
  logic       sck_in, sck_out, sck_oe;
  logic       mosi_in, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe;
  logic       ss_n;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic finished = 1'b0;

  logic [7:0] m_rx;
  int         m_e0, m_e1, m_edges;

  spi_duplex_unit i_spi_duplex_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(miso_in), .miso_o(miso_out), .miso_oe_o(miso_oe),
    .ss_ni(ss_n)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1ns d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // behavioural slave partner for master tests
  task automatic partner(input logic cpol, input logic cpha, input logic [7:0] stx);
    logic [7:0] sh;
    sh = stx;
    m_rx = 8'h00;
    m_edges = 0;
    if (!cpha) miso_in = sh[7];
    for (int e = 0; e < 16; e++) begin
      @(sck_out);
      if (e == 0) m_e0 = cyc;
      if (e == 1) m_e1 = cyc;
      if ((sck_out != cpol) == !cpha) begin
        m_rx = {m_rx[6:0], mosi_out};
      end else if (cpha) begin
        miso_in = sh[7];
        sh = {sh[6:0], 1'b0};
      end else begin
        sh = {sh[6:0], 1'b0};
        miso_in = sh[7];
      end
      m_edges++;
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic test_reset();
    logic [7:0] d;
    reg_rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    reg_rd(2'd1, d); check("R1 status", d, 8'h00);
    reg_rd(2'd2, d); check("R1 data", d, 8'h00);
    check("R1 oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic test_master(input logic cpol, input logic cpha, input logic [1:0] rate,
                             input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] d;
    reg_wr(2'd0, {1'b0, 1'b1, rate, cpha, cpol, 1'b1, 1'b1});
    @(negedge clk);
    check("R4 idle level", sck_out, cpol);
    check("R8 master drives", {sck_oe, mosi_oe}, 2'b11);
    fork
      partner(cpol, cpha, stx);
      reg_wr(2'd2, tx);
    join
    wait_irq();
    check("R2 edge count", m_edges, 16);
    check("R2 half period", m_e1 - m_e0, 32'd2 << rate);
    check("R3 mosi byte", m_rx, tx);
    check("R4 back to idle", sck_out, cpol);
    check("R10 irq on done", irq, 1'b1);
    reg_rd(2'd1, d); check("R5 done flag", d, 8'h80);
    reg_rd(2'd2, d); check("R3 received byte", d, stx);
    reg_rd(2'd1, d); check("R6 cleared", d, 8'h00);
    check("R10 irq dropped", irq, 1'b0);
  endtask

  task automatic test_clear_order();
    logic [7:0] d;
    reg_wr(2'd0, 8'h43);
    fork
      partner(1'b0, 1'b0, 8'hE7);
      reg_wr(2'd2, 8'h18);
    join
    wait_irq();
    reg_rd(2'd2, d); check("R3 data early", d, 8'hE7);
    reg_rd(2'd1, d); check("R6 data first keeps flag", d, 8'h80);
    reg_rd(2'd2, d);
    reg_rd(2'd1, d); check("R6 proper order clears", d, 8'h00);
  endtask

  task automatic test_wcol();
    logic [7:0] d;
    reg_wr(2'd0, 8'h33);
    fork
      partner(1'b0, 1'b0, 8'h3C);
      begin
        reg_wr(2'd2, 8'h81);
        repeat (40) @(posedge clk);
        reg_wr(2'd2, 8'h7E);
      end
    join
    repeat (6) @(negedge clk);
    check("R7 byte unchanged", m_rx, 8'h81);
    reg_rd(2'd1, d); check("R7 collision and done", d, 8'hC0);
    reg_rd(2'd2, d); check("R7 received intact", d, 8'h3C);
    reg_rd(2'd1, d); check("R6 collision cleared", d, 8'h00);
  endtask

  task automatic test_modf();
    logic [7:0] d;
    reg_wr(2'd0, 8'h43);
    @(negedge clk);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 outputs released", {sck_oe, mosi_oe}, 2'b00);
    check("R10 irq on fault", irq, 1'b1);
    reg_rd(2'd0, d); check("R8 master bit cleared", d, 8'h41);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(2'd0, 8'h41);
    reg_rd(2'd1, d); check("R11 fault sticky", d, 8'h10);
    reg_wr(2'd0, 8'h43);
    repeat (2) @(negedge clk);
    reg_rd(2'd1, d); check("R11 fault cleared", d, 8'h00);
    check("R11 drivers back", {sck_oe, mosi_oe}, 2'b11);
  endtask

  task automatic test_slave(input logic cpol, input logic cpha,
                            input logic [7:0] dtx, input logic [7:0] mtx);
    logic [7:0] d;
    logic [7:0] got;
    got = 8'h00;
    sck_in = cpol;
    reg_wr(2'd0, {4'b0000, cpha, cpol, 2'b01});
    reg_wr(2'd2, dtx);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 miso driven", {miso_oe, sck_oe}, 2'b10);
    for (int b = 7; b >= 0; b--) begin
      if (!cpha) begin
        mosi_in = mtx[b];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = ~cpol;
        repeat (8) @(negedge clk);
        sck_in = cpol;
      end else begin
        sck_in = ~cpol;
        mosi_in = mtx[b];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 miso released", miso_oe, 1'b0);
    check("R9 slave sent", got, dtx);
    reg_rd(2'd1, d); check("R5 slave done", d, 8'h80);
    reg_rd(2'd2, d); check("R9 slave received", d, mtx);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0; ss_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset();
    test_master(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
    test_master(1'b1, 1'b0, 2'd1, 8'h5A, 8'hC3);
    test_master(1'b0, 1'b1, 2'd2, 8'h96, 8'h0F);
    test_master(1'b1, 1'b1, 2'd3, 8'h01, 8'h80);
    test_clear_order();
    test_wcol();
    test_modf();
    reg_wr(2'd0, 8'h00);
    test_slave(1'b0, 1'b0, 8'h96, 8'h5A);
    test_slave(1'b1, 1'b1, 8'hC1, 8'h2E);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
      $finish;
    end
  end
endmodule